// File: doc/BRIEF.md
# Three-and-a-half-digit direct-drive LCD segment driver

This block takes a signed conversion result of 0 to 1999, held as a plain binary count with a separate sign flag and an overrange flag, and produces the static drive pattern for a non-multiplexed seven-segment liquid crystal panel. The panel has three full digits, a leading half digit that can show only blank or "1", and a minus sign. Every output toggles with a common backplane square wave. A segment that is off moves in phase with the backplane. A segment that is on moves in anti-phase with it. Either way, the glass sees no net DC voltage.

A result is taken on a one-cycle valid strobe. A small sequencer then splits the count into decimal digits by repeated subtraction. Its states are `S_IDLE` (waiting), `S_HALF` (decide the leading "1" and overrange), `S_DIGIT` (subtract the current decimal weight or step down one digit) and `S_COMMIT` (hand the whole new frame to the display register).

The transitions are:
- `S_IDLE` goes to `S_HALF` on the strobe.
- `S_HALF` goes to `S_COMMIT` on overrange, and to `S_DIGIT` otherwise.
- `S_DIGIT` stays in place while the remainder covers the weight. It goes to `S_COMMIT` after the tens digit is done.
- `S_COMMIT` always returns to `S_IDLE`.

Because the frame is copied only in `S_COMMIT`, the panel never shows a mix of old and new digits. A lamp-test input forces every segment on.

Top module: `lcd_half_digit_drv`

## Requirements
- R1: The units, tens and hundreds digits of the count are shown on `seg_digit[6:0]`, `[13:7]` and `[20:14]`. Within a digit, bit 0 is segment a and bit 6 is segment g. The digits 0 to 9 light the patterns 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R2: The half-digit output is on for counts 1000 to 1999 and off for counts below 1000.
- R3: A count of zero shows "000" on the three lower digits with the half digit off.
- R4: The minus output is on exactly when the sign flag of the shown result is set, including for a zero count and during overrange.
- R5: `backplane` equals `bp_phase` delayed by one clock. Each other output equals that backplane XOR its on-bit, and all outputs are registered.
- R6: While `lamp_test` is high, every segment, the half digit and the minus sign are on, one clock later. The stored reading is unchanged when the input is released.
- R7: When the overrange flag is set with the strobe, the half digit is on and all three lower digits are blank. The minus sign still follows the sign flag.
- R8: A count above 1999 is treated as overrange even if the flag is clear.
- R9: A new reading is copied into the display 4+H+T clocks after the strobe edge, where H is the hundreds digit and T is the tens digit. For overrange it is copied 2 clocks after the strobe edge. It shows on the outputs one clock after it is copied, and the previous reading stays shown until then.
- R10: A strobe that arrives before the current reading has been copied is dropped. A strobe in the clock after the copy is accepted.
- R11: During reset all outputs are low, and the stored reading is a positive zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_phase | input | 1 | Backplane square wave to be distributed |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_count | input | COUNT_W | Binary magnitude of the result |
| res_neg | input | 1 | Result is negative |
| res_ovr | input | 1 | Result is out of range |
| lamp_test | input | 1 | Force every segment on |
| seg_digit | output | NDIG*7 | Segment drives, units digit in the low seven bits |
| seg_half | output | 1 | Drive for the leading "1" (two segments tied together) |
| seg_minus | output | 1 | Drive for the minus sign |
| backplane | output | 1 | Common backplane drive |

## Verification
Lamp test and frame copy can fall in the same clock: the forced pattern is computed from the old frame in the same edge that the new frame is copied. The bench tracks the copy countdown of its own model. It raises `lamp_test` for exactly the clock whose edge performs the copy, then drops it. A model compared on every clock then requires all-on drive in that one output cycle and the new reading immediately afterwards. A second collision, a strobe landing while a reading is still being split or in the clock right after the copy, is judged the same way. It must be dropped in the first case and taken in the second.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int SEG_W = 7;

    typedef struct packed {
        logic neg;
        logic ovr;
        logic half;
    } lcd_flags_t;

    // bit 0 = segment a ... bit 6 = segment g
    function automatic logic [SEG_W-1:0] seg7_of(input logic [3:0] d);
        logic [SEG_W-1:0] s;
        unique case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd_bcd_split.sv
module lcd_bcd_split
    import lcd_drv_pkg::*;
#(
    parameter int NDIG     = 3,
    parameter int COUNT_W  = 11,
    parameter int MAX_READ = 1999
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    input  logic [COUNT_W-1:0]    count,
    input  logic                  neg,
    input  logic                  ovr,
    output logic                  upd,
    output logic [NDIG-1:0][3:0]  dig,
    output lcd_flags_t            flags
);

    localparam int IDX_W = (NDIG > 2) ? $clog2(NDIG) : 1;
    localparam logic [COUNT_W-1:0] HALF_WT = COUNT_W'(10 ** NDIG);
    localparam logic [COUNT_W-1:0] MAX_VAL = COUNT_W'(MAX_READ);
    localparam logic [IDX_W-1:0]   TOP_IDX = IDX_W'(NDIG - 1);
    localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(1);

    typedef enum logic [1:0] {
        S_IDLE,
        S_HALF,
        S_DIGIT,
        S_COMMIT
    } cv_state_t;

    cv_state_t            state, nxt;
    logic [COUNT_W-1:0]   rem;
    logic [IDX_W-1:0]     idx;
    logic [COUNT_W-1:0]   cur_wt;
    logic                 take;

    function automatic logic [COUNT_W-1:0] weight_of(input logic [IDX_W-1:0] i);
        int p;
        p = 1;
        for (int k = 0; k < NDIG; k++) begin
            if (k < int'(i)) p = p * 10;
        end
        return COUNT_W'(p);
    endfunction

    assign cur_wt = weight_of(idx);
    assign take   = (rem >= cur_wt);
    assign upd    = (state == S_COMMIT);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (strobe) nxt = S_HALF;
            S_HALF:   nxt = flags.ovr ? S_COMMIT : S_DIGIT;
            S_DIGIT:  if (!take && idx == LAST_IDX) nxt = S_COMMIT;
            S_COMMIT: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            idx   <= TOP_IDX;
            dig   <= '0;
            flags <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (strobe) begin
                        rem        <= count;
                        idx        <= TOP_IDX;
                        dig        <= '0;
                        flags.neg  <= neg;
                        flags.ovr  <= ovr || (count > MAX_VAL);
                        flags.half <= 1'b0;
                    end
                end
                S_HALF: begin
                    if (flags.ovr) begin
                        flags.half <= 1'b1;
                    end else if (rem >= HALF_WT) begin
                        rem        <= rem - HALF_WT;
                        flags.half <= 1'b1;
                    end
                end
                S_DIGIT: begin
                    if (take) begin
                        rem      <= rem - cur_wt;
                        dig[idx] <= dig[idx] + 4'd1;
                    end else if (idx == LAST_IDX) begin
                        dig[0] <= rem[3:0];
                    end else begin
                        idx <= idx - LAST_IDX;
                    end
                end
                S_COMMIT: begin
                end
                default: begin
                end
            endcase
        end
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd); // R9
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) && strobe |=> $stable(flags.neg) && $stable(flags.ovr)); // R10

    for (genvar g = 0; g < NDIG; g++) begin : g_rng
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            upd && !flags.ovr |-> dig[g] <= 4'd9); // R1
    end

endmodule

// File: rtl/lcd_frame_hold.sv
module lcd_frame_hold
    import lcd_drv_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd,
    input  logic [NDIG-1:0][3:0]  dig_in,
    input  lcd_flags_t            flags_in,
    output logic [NDIG-1:0][3:0]  dig_q,
    output lcd_flags_t            flags_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_q   <= '0;
            flags_q <= '0;
        end else if (upd) begin
            dig_q   <= dig_in;
            flags_q <= flags_in;
        end
    end

    AST_FRAME_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(dig_q) && $stable(flags_q)); // R9

endmodule

// File: rtl/lcd_phase_out.sv
module lcd_phase_out
    import lcd_drv_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bp_phase,
    input  logic                     lamp_test,
    input  logic [NDIG-1:0][3:0]     dig_q,
    input  lcd_flags_t               flags_q,
    output logic [NDIG*SEG_W-1:0]    seg_digit,
    output logic                     seg_half,
    output logic                     seg_minus,
    output logic                     backplane
);

    logic [NDIG*SEG_W-1:0] on_bits;
    logic                  half_on;
    logic                  minus_on;

    for (genvar g = 0; g < NDIG; g++) begin : g_enc
        always_comb begin
            if (lamp_test)        on_bits[g*SEG_W +: SEG_W] = '1;
            else if (flags_q.ovr) on_bits[g*SEG_W +: SEG_W] = '0;
            else                  on_bits[g*SEG_W +: SEG_W] = seg7_of(dig_q[g]);
        end
    end

    assign half_on  = lamp_test | flags_q.half | flags_q.ovr;
    assign minus_on = lamp_test | flags_q.neg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_digit <= '0;
            seg_half  <= 1'b0;
            seg_minus <= 1'b0;
            backplane <= 1'b0;
        end else begin
            seg_digit <= on_bits ^ {(NDIG*SEG_W){bp_phase}};
            seg_half  <= half_on ^ bp_phase;
            seg_minus <= minus_on ^ bp_phase;
            backplane <= bp_phase;
        end
    end

endmodule

// File: rtl/lcd_half_digit_drv.sv
module lcd_half_digit_drv
    import lcd_drv_pkg::*;
#(
    parameter int NDIG     = 3,
    parameter int COUNT_W  = 11,
    parameter int MAX_READ = 1999
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bp_phase,
    input  logic                     res_valid,
    input  logic [COUNT_W-1:0]       res_count,
    input  logic                     res_neg,
    input  logic                     res_ovr,
    input  logic                     lamp_test,
    output logic [NDIG*SEG_W-1:0]    seg_digit,
    output logic                     seg_half,
    output logic                     seg_minus,
    output logic                     backplane
);

    localparam int DW = NDIG * SEG_W;

    logic                  upd;
    logic [NDIG-1:0][3:0]  dig_new, dig_q;
    lcd_flags_t            flags_new, flags_q;

    lcd_bcd_split #(.NDIG(NDIG), .COUNT_W(COUNT_W), .MAX_READ(MAX_READ)) u_split (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (res_valid),
        .count  (res_count),
        .neg    (res_neg),
        .ovr    (res_ovr),
        .upd    (upd),
        .dig    (dig_new),
        .flags  (flags_new)
    );

    lcd_frame_hold #(.NDIG(NDIG)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .dig_in   (dig_new),
        .flags_in (flags_new),
        .dig_q    (dig_q),
        .flags_q  (flags_q)
    );

    lcd_phase_out #(.NDIG(NDIG)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_phase  (bp_phase),
        .lamp_test (lamp_test),
        .dig_q     (dig_q),
        .flags_q   (flags_q),
        .seg_digit (seg_digit),
        .seg_half  (seg_half),
        .seg_minus (seg_minus),
        .backplane (backplane)
    );

    AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lamp_test) |-> (seg_digit == ~{DW{backplane}}) && (seg_half != backplane)
                             && (seg_minus != backplane)); // R6
    AST_OVR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lamp_test) && $past(flags_q.ovr) |-> (seg_digit == {DW{backplane}})
                                                  && (seg_half != backplane)); // R7
    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lamp_test) |-> (seg_minus != backplane) == $past(flags_q.neg)); // R4
    AST_BP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(backplane) |-> $past(bp_phase)); // R5

endmodule

// File: tb/tb_lcd_half_digit_drv.sv
`timescale 1ns/1ps
module tb_lcd_half_digit_drv;

    localparam int NDIG = 3;
    localparam int COUNT_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bp_phase = 1'b0;
    logic res_valid = 1'b0;
    logic [COUNT_W-1:0] res_count = '0;
    logic res_neg = 1'b0;
    logic res_ovr = 1'b0;
    logic lamp_test = 1'b0;
    logic [20:0] seg_digit;
    logic seg_half, seg_minus, backplane;

    always #2 clk = ~clk;

    lcd_half_digit_drv #(.NDIG(NDIG), .COUNT_W(COUNT_W), .MAX_READ(1999)) dut (
        .clk(clk), .rst_n(rst_n), .bp_phase(bp_phase), .res_valid(res_valid),
        .res_count(res_count), .res_neg(res_neg), .res_ovr(res_ovr),
        .lamp_test(lamp_test), .seg_digit(seg_digit), .seg_half(seg_half),
        .seg_minus(seg_minus), .backplane(backplane)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R11";

    // behavioural model state
    int m_cd = 0;
    int m_u = 0, m_t = 0, m_h = 0;
    bit m_half = 0, m_neg = 0, m_ovr = 0;
    int p_u, p_t, p_h;
    bit p_half, p_neg, p_ovr;
    logic [23:0] exp_vec = '0;

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [23:0] build(input int u, input int t, input int h,
                                          input bit half, input bit neg, input bit ovr,
                                          input bit tst, input bit bp);
        logic [6:0] su, st, sh;
        bit ho, mo;
        if (tst) begin su = 7'h7F; st = 7'h7F; sh = 7'h7F; end
        else if (ovr) begin su = 0; st = 0; sh = 0; end
        else begin su = pat(u); st = pat(t); sh = pat(h); end
        ho = tst | half | ovr;
        mo = tst | neg;
        return {sh ^ {7{bp}}, st ^ {7{bp}}, su ^ {7{bp}}, ho ^ bp, mo ^ bp, bp};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cd = 0; m_u = 0; m_t = 0; m_h = 0;
            m_half = 0; m_neg = 0; m_ovr = 0;
            exp_vec = '0;
        end else begin
            exp_vec = build(m_u, m_t, m_h, m_half, m_neg, m_ovr, lamp_test, bp_phase);
            if (m_cd == 0 && res_valid) begin
                int v;
                v = int'(res_count);
                p_neg = res_neg;
                p_ovr = res_ovr || (v > 1999);
                if (p_ovr) begin
                    p_half = 1; p_u = 0; p_t = 0; p_h = 0; m_cd = 2;
                end else begin
                    p_half = (v >= 1000);
                    p_h = (v / 100) % 10; p_t = (v / 10) % 10; p_u = v % 10;
                    m_cd = 4 + p_h + p_t;
                end
            end else if (m_cd > 0) begin
                m_cd = m_cd - 1;
                if (m_cd == 0) begin
                    m_half = p_half; m_neg = p_neg; m_ovr = p_ovr;
                    if (!p_ovr) begin m_u = p_u; m_t = p_t; m_h = p_h; end
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if ({seg_digit, seg_half, seg_minus, backplane} !== exp_vec) begin
                failures++;
                $display("FAIL %s per-clock: actual=%h expected=%h", cur_req,
                         {seg_digit, seg_half, seg_minus, backplane}, exp_vec);
            end
        end
    end

    // backplane square wave
    int bp_cnt = 0;
    always @(negedge clk) begin
        bp_cnt++;
        if (bp_cnt == 3) begin bp_cnt = 0; bp_phase <= ~bp_phase; end
    end

    task automatic check_frame(input string tag, input int v, input bit neg, input bit ovr,
                               input bit tst);
        logic [23:0] e;
        bit o;
        o = ovr || (v > 1999);
        e = build(v % 10, (v / 10) % 10, (v / 100) % 10, (v >= 1000) || o, neg, o, tst, backplane);
        checks++;
        if ({seg_digit, seg_half, seg_minus, backplane} !== e) begin
            failures++;
            $display("FAIL %s value %0d: actual=%h expected=%h", tag, v,
                     {seg_digit, seg_half, seg_minus, backplane}, e);
        end
    endtask

    task automatic strobe_now(input int v, input bit neg, input bit ovr);
        res_valid = 1; res_count = COUNT_W'(v); res_neg = neg; res_ovr = ovr;
        @(negedge clk);
        res_valid = 0;
    endtask

    task automatic present(input int v, input bit neg, input bit ovr);
        @(negedge clk);
        strobe_now(v, neg, ovr);
    endtask

    task automatic settle();
        while (m_cd != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R11";
        checks++;
        if ({seg_digit, seg_half, seg_minus, backplane} !== 24'h0) begin
            failures++;
            $display("FAIL R11 reset: actual=%h expected=%h",
                     {seg_digit, seg_half, seg_minus, backplane}, 24'h0);
        end
        rst_n = 1;
        repeat (2) @(negedge clk);
        check_frame("R11", 0, 0, 0, 0);

        cur_req = "R3";  present(0, 0, 0);    settle(); check_frame("R3", 0, 0, 0, 0);
        cur_req = "R4";  present(0, 1, 0);    settle(); check_frame("R4", 0, 1, 0, 0);
        cur_req = "R1";  present(7, 0, 0);    settle(); check_frame("R1", 7, 0, 0, 0);
        present(58, 0, 0);   settle(); check_frame("R1", 58, 0, 0, 0);
        present(999, 1, 0);  settle(); check_frame("R1", 999, 1, 0, 0);
        present(346, 0, 0);  settle(); check_frame("R1", 346, 0, 0, 0);
        cur_req = "R2";  present(1000, 0, 0); settle(); check_frame("R2", 1000, 0, 0, 0);
        present(1999, 1, 0); settle(); check_frame("R2", 1999, 1, 0, 0);
        present(1234, 0, 0); settle(); check_frame("R2", 1234, 0, 0, 0);
        cur_req = "R5";
        repeat (4) begin @(negedge clk); check_frame("R5", 1234, 0, 0, 0); end
        cur_req = "R7";  present(55, 1, 1);   settle(); check_frame("R7", 55, 1, 1, 0);
        cur_req = "R8";  present(2000, 0, 0); settle(); check_frame("R8", 2000, 0, 0, 0);
        present(2047, 1, 0); settle(); check_frame("R8", 2047, 1, 0, 0);

        cur_req = "R9";
        present(880, 0, 0);
        @(negedge clk);
        check_frame("R9", 2047, 1, 0, 0);   // old reading still shown
        settle(); check_frame("R9", 880, 0, 0, 0);

        cur_req = "R10";
        present(123, 0, 0);
        strobe_now(456, 1, 0);              // dropped: still busy
        settle(); check_frame("R10", 123, 0, 0, 0);
        present(789, 0, 0);
        while (m_cd != 0) @(negedge clk);
        strobe_now(456, 1, 0);              // first clock after the copy: taken
        settle(); check_frame("R10", 456, 1, 0, 0);

        cur_req = "R6";
        lamp_test = 1;
        repeat (3) @(negedge clk);
        check_frame("R6", 456, 1, 0, 1);
        lamp_test = 0;
        @(negedge clk);
        check_frame("R6", 456, 1, 0, 0);
        present(1500, 0, 0);
        while (m_cd != 1) @(negedge clk);
        lamp_test = 1;                      // raised for the copy edge only
        @(negedge clk);
        check_frame("R6", 1500, 0, 0, 1);
        lamp_test = 0;
        @(negedge clk);
        check_frame("R6", 1500, 0, 0, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule